// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector Core

This block is the digital heart of an integer-N frequency synthesizer. It holds two counters: a reference counter whose ratio comes from a four-level select input, and a feedback counter that divides the oscillator by a fixed 2464. A tristate phase-frequency detector compares the two divided outputs and issues up and down commands to an external charge pump. With the nominal reference crystals, every select setting gives a 512 kHz comparison rate, which places the locked oscillator at 1261.568 MHz.

The design runs in one clock domain. The reference clock and the oscillator clock reach it as single-cycle enable strobes, `ref_ce` and `osc_ce`. Each analog pin that can be tied low, tied high, biased to mid-supply or left floating is modelled as a 2-bit level code. A mode input sets the charge-pump current range. It can also turn off the charge pump and the loop amplifier, and it can route both divided signals to two monitor outputs.

Top module: `pll_div_pfd`

## Requirements
- R1: Once a feedback pulse has been seen, the feedback divider produces a pulse every 2464 `osc_ce` strobes.
- R2: The reference ratio follows `sel_lvl` (00 ground, 01 mid-supply, 10 open, 11 supply). 00 gives 35, 01 gives 32, 10 gives 48 and 11 gives 36 `ref_ce` strobes per pulse.
- R3: Each divider pulse is high for exactly one clock cycle.
- R4: A change of `sel_lvl` does not shorten the count in progress. The new ratio takes effect from the next wrap.
- R5: When a reference pulse arrives first, `pd_up` rises one cycle after it. It stays high until the cycle in which the two flags are cleared.
- R6: When a feedback pulse arrives first, `pd_dn` rises one cycle after it, with the same timing.
- R7: When both flags are set, they overlap for exactly one cycle and are both cleared on the next cycle.
- R8: Mode 00 (ground) enables the charge pump at high current (`cp_hi`=1) with the amplifier on. Mode 11 (supply) enables the charge pump at low current (`cp_hi`=0) with the amplifier on.
- R9: Mode 01 (mid-supply) disables the charge pump and the amplifier. `pd_up` and `pd_dn` then stay low whatever the phase relation.
- R10: Mode 10 (open) disables the charge pump and drives the divided reference and feedback pulses on `mon_ref` and `mon_fb`. In every other mode both monitors stay low.
- R11: While reset is held and directly after it, `pd_up`, `pd_dn`, `mon_ref` and `mon_fb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ce | input | 1 | One strobe per reference clock period |
| osc_ce | input | 1 | One strobe per oscillator clock period |
| sel_lvl | input | 2 | Reference ratio select level code |
| mode_lvl | input | 2 | Mode level code |
| pd_up | output | 1 | Source-current command |
| pd_dn | output | 1 | Sink-current command |
| cp_en | output | 1 | Charge pump enabled |
| cp_hi | output | 1 | High current range selected |
| amp_en | output | 1 | Loop amplifier enabled |
| tst_en | output | 1 | Monitors enabled |
| mon_ref | output | 1 | Divided reference monitor |
| mon_fb | output | 1 | Divided feedback monitor |

## Verification
A wrong counter load or a wrong ratio choice appears as a wrong spacing between monitor pulses. Nothing shows until the first wrap, which comes within 48 strobes for the reference counter and within 2464 strobes for the feedback counter. A stuck or mis-cleared detector flag holds `pd_up` or `pd_dn` high past the one-cycle overlap, or leaves the command low in the cycle after its edge. Both faults are therefore visible within two cycles of the second edge. A decode fault appears at once on the mode outputs, or as monitor pulses in a mode that should keep the monitors silent.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  typedef enum logic [1:0] {
    LVL_GND  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_OPEN = 2'b10,
    LVL_VCC  = 2'b11
  } lvl_e;

  typedef struct packed {
    logic cp_en;
    logic cp_hi;
    logic amp_en;
    logic tst_en;
  } mode_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pllc_divider.sv
module pllc_divider #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] ratio,
  output logic         tc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;
  logic         tc_q;
  logic         wrap;

  assign wrap = ce && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= wrap;
      if (ce) begin
        if (cnt_q == '0) cnt_q <= ratio - W'(1);
        else             cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign tc  = tc_q;
  assign cnt = cnt_q;

endmodule

// File: rtl/pllc_pfd.sv
module pllc_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up,
  output logic dn,
  output logic clr
);

  logic up_q, dn_q;

  assign clr = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (clr) begin
      up_q <= ref_ev;
      dn_q <= fb_ev;
    end else begin
      if (ref_ev) up_q <= 1'b1;
      if (fb_ev)  dn_q <= 1'b1;
    end
  end

  assign up = up_q;
  assign dn = dn_q;

endmodule

// File: rtl/pllc_mode_dec.sv
module pllc_mode_dec
  import pllc_pkg::*;
(
  input  logic [1:0] lvl,
  output mode_t      mode
);

  always_comb begin
    mode = '0;
    case (lvl_e'(lvl))
      LVL_GND:  begin mode.cp_en = 1'b1; mode.cp_hi = 1'b1; mode.amp_en = 1'b1; end
      LVL_VCC:  begin mode.cp_en = 1'b1; mode.cp_hi = 1'b0; mode.amp_en = 1'b1; end
      LVL_MID:  begin mode.cp_en = 1'b0; mode.amp_en = 1'b0; end
      LVL_OPEN: begin mode.cp_en = 1'b0; mode.amp_en = 1'b1; mode.tst_en = 1'b1; end
      default:  mode = '0;
    endcase
  end

endmodule

// File: rtl/pll_div_pfd.sv
module pll_div_pfd
  import pllc_pkg::*;
#(
  parameter int FB_DIV       = 2464,
  parameter int REF_DIV_GND  = 35,
  parameter int REF_DIV_MID  = 32,
  parameter int REF_DIV_OPEN = 48,
  parameter int REF_DIV_VCC  = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_ce,
  input  logic       osc_ce,
  input  logic [1:0] sel_lvl,
  input  logic [1:0] mode_lvl,
  output logic       pd_up,
  output logic       pd_dn,
  output logic       cp_en,
  output logic       cp_hi,
  output logic       amp_en,
  output logic       tst_en,
  output logic       mon_ref,
  output logic       mon_fb
);

  localparam int REF_MAX = max4(REF_DIV_GND, REF_DIV_MID, REF_DIV_OPEN, REF_DIV_VCC);
  localparam int REF_W   = $clog2(REF_MAX + 1);
  localparam int FB_W    = $clog2(FB_DIV + 1);

  function automatic logic [REF_W-1:0] pick_ratio(input logic [1:0] lvl);
    case (lvl_e'(lvl))
      LVL_GND:  return REF_W'(REF_DIV_GND);
      LVL_MID:  return REF_W'(REF_DIV_MID);
      LVL_OPEN: return REF_W'(REF_DIV_OPEN);
      default:  return REF_W'(REF_DIV_VCC);
    endcase
  endfunction

  logic [REF_W-1:0] ref_ratio;
  logic [REF_W-1:0] ref_cnt;
  logic [FB_W-1:0]  fb_cnt;
  logic             ref_tc, fb_tc;
  logic             up_q, dn_q, pfd_clr;
  mode_t            mode;

  assign ref_ratio = pick_ratio(sel_lvl);

  pllc_divider #(.W(REF_W)) u_refdiv (
    .clk(clk), .rst_n(rst_n), .ce(ref_ce), .ratio(ref_ratio),
    .tc(ref_tc), .cnt(ref_cnt)
  );

  pllc_divider #(.W(FB_W)) u_fbdiv (
    .clk(clk), .rst_n(rst_n), .ce(osc_ce), .ratio(FB_W'(FB_DIV)),
    .tc(fb_tc), .cnt(fb_cnt)
  );

  pllc_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_ev(ref_tc), .fb_ev(fb_tc),
    .up(up_q), .dn(dn_q), .clr(pfd_clr)
  );

  pllc_mode_dec u_dec (.lvl(mode_lvl), .mode(mode));

  assign cp_en   = mode.cp_en;
  assign cp_hi   = mode.cp_hi;
  assign amp_en  = mode.amp_en;
  assign tst_en  = mode.tst_en;
  assign pd_up   = up_q & mode.cp_en;
  assign pd_dn   = dn_q & mode.cp_en;
  assign mon_ref = ref_tc & mode.tst_en;
  assign mon_fb  = fb_tc & mode.tst_en;

endmodule

// File: rtl/pllc_chk.sv
module pllc_chk #(
  parameter int FB_DIV  = 2464,
  parameter int FB_W    = 12,
  parameter int REF_MAX = 48,
  parameter int REF_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tc,
  input logic             fb_tc,
  input logic             up_q,
  input logic             dn_q,
  input logic             pfd_clr,
  input logic [1:0]       mode_lvl,
  input logic             pd_up,
  input logic             pd_dn,
  input logic             amp_en,
  input logic             mon_ref,
  input logic             mon_fb,
  input logic [FB_W-1:0]  fb_cnt,
  input logic [REF_W-1:0] ref_cnt
);

  AST_FB_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) fb_cnt < FB_W'(FB_DIV)); // R1
  AST_REF_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) ref_cnt < REF_W'(REF_MAX)); // R2
  AST_TC_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) ref_tc |=> !ref_tc); // R3
  AST_FB_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) fb_tc |=> !fb_tc); // R3
  AST_UP_SET:     assert property (@(posedge clk) disable iff (!rst_n) (ref_tc && !(up_q && dn_q)) |=> up_q); // R5
  AST_DN_SET:     assert property (@(posedge clk) disable iff (!rst_n) (fb_tc && !(up_q && dn_q)) |=> dn_q); // R6
  AST_PFD_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n) (pfd_clr && !ref_tc && !fb_tc) |=> (!up_q && !dn_q)); // R7
  AST_MID_OFF:    assert property (@(posedge clk) disable iff (!rst_n) (mode_lvl == 2'b01) |-> (!pd_up && !pd_dn && !amp_en)); // R9
  AST_MON_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (mode_lvl != 2'b10) |-> (!mon_ref && !mon_fb)); // R10

endmodule

bind pll_div_pfd pllc_chk #(
  .FB_DIV(FB_DIV), .FB_W(FB_W), .REF_MAX(REF_MAX), .REF_W(REF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tc(ref_tc), .fb_tc(fb_tc),
  .up_q(up_q), .dn_q(dn_q), .pfd_clr(pfd_clr), .mode_lvl(mode_lvl),
  .pd_up(pd_up), .pd_dn(pd_dn), .amp_en(amp_en), .mon_ref(mon_ref),
  .mon_fb(mon_fb), .fb_cnt(fb_cnt), .ref_cnt(ref_cnt)
);

// File: tb/sim_pll_div_pfd.sv
module sim_pll_div_pfd;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ce = 1'b0, osc_ce = 1'b0;
  logic [1:0] sel_lvl = 2'b00, mode_lvl = 2'b10;
  logic pd_up, pd_dn, cp_en, cp_hi, amp_en, tst_en, mon_ref, mon_fb;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pll_div_pfd u0 (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .osc_ce(osc_ce),
    .sel_lvl(sel_lvl), .mode_lvl(mode_lvl), .pd_up(pd_up), .pd_dn(pd_dn),
    .cp_en(cp_en), .cp_hi(cp_hi), .amp_en(amp_en), .tst_en(tst_en),
    .mon_ref(mon_ref), .mon_fb(mon_fb)
  );

  // row: sel, mode, ratio, cp_en, cp_hi, amp_en, tst_en
  localparam int ROWS = 4;
  localparam int TV [ROWS][7] = '{
    '{0, 0, 35, 1, 1, 1, 0},
    '{1, 1, 32, 0, 0, 0, 0},
    '{2, 2, 48, 0, 0, 1, 1},
    '{3, 3, 36, 1, 0, 1, 0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_ce = 1'b0; osc_ce = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_ref(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!mon_ref && c < 5000);
  endtask

  task automatic wait_fb(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!mon_fb && c < 10000);
  endtask

  task automatic pfd_run(input bit ref_first, input int gap,
                         output int nu, output int nd, output int nb);
    nu = 0; nd = 0; nb = 0;
    @(negedge clk);
    if (ref_first) ref_ce = 1'b1; else osc_ce = 1'b1;
    for (int k = 0; k < gap + 10; k++) begin
      @(negedge clk);
      ref_ce = 1'b0; osc_ce = 1'b0;
      if (k == gap - 1) begin
        if (ref_first) osc_ce = 1'b1; else ref_ce = 1'b1;
      end
      if (pd_up) nu++;
      if (pd_dn) nd++;
      if (pd_up && pd_dn) nb++;
    end
  endtask

  initial begin
    int c, nu, nd, nb, cnt;
    do_reset();
    // R11 reset state with monitors enabled
    chk(!pd_up && !pd_dn, "R11 pd idle", {pd_up, pd_dn}, 0);
    chk(!mon_ref && !mon_fb, "R11 monitors idle", {mon_ref, mon_fb}, 0);

    ref_ce = 1'b1;
    for (int i = 0; i < ROWS; i++) begin
      sel_lvl = 2'(TV[i][0]);
      mode_lvl = 2'b10;
      wait_ref(c); wait_ref(c);
      wait_ref(c);
      chk(c == TV[i][2], "R2 reference period", c, TV[i][2]);
      @(negedge clk);
      chk(!mon_ref, "R3 reference pulse width", mon_ref, 0);
      mode_lvl = 2'(TV[i][1]);
      #1;
      chk(cp_en == TV[i][3][0], "R8/R9 cp_en decode", cp_en, TV[i][3]);
      chk(cp_hi == TV[i][4][0], "R8 cp_hi decode", cp_hi, TV[i][4]);
      chk(amp_en == TV[i][5][0], "R9 amp_en decode", amp_en, TV[i][5]);
      chk(tst_en == TV[i][6][0], "R10 tst_en decode", tst_en, TV[i][6]);
      if (TV[i][1] != 2) begin
        cnt = 0;
        repeat (60) begin @(negedge clk); if (mon_ref) cnt++; end
        chk(cnt == 0, "R10 monitor silent outside open mode", cnt, 0);
      end
    end

    // R4: switch 48 -> 32 right after a pulse
    mode_lvl = 2'b10; sel_lvl = 2'b10;
    wait_ref(c); wait_ref(c);
    sel_lvl = 2'b01;
    wait_ref(c);
    chk(c == 48, "R4 count in progress kept", c, 48);
    wait_ref(c);
    chk(c == 32, "R4 new ratio after wrap", c, 32);

    // R1 feedback period
    ref_ce = 1'b0; osc_ce = 1'b1;
    wait_fb(c); wait_fb(c);
    wait_fb(c);
    chk(c == 2464, "R1 feedback period", c, 2464);
    @(negedge clk);
    chk(!mon_fb, "R3 feedback pulse width", mon_fb, 0);
    osc_ce = 1'b0;

    // R5/R7 reference leads by 5
    mode_lvl = 2'b00; do_reset();
    pfd_run(1'b1, 5, nu, nd, nb);
    chk(nu == 6, "R5 up duration on reference lead", nu, 6);
    chk(nd == 1, "R5 down only overlap cycle", nd, 1);
    chk(nb == 1, "R7 one-cycle overlap", nb, 1);
    chk(!pd_up && !pd_dn, "R7 flags cleared", {pd_up, pd_dn}, 0);

    // R6 feedback leads by 5
    do_reset();
    pfd_run(1'b0, 5, nu, nd, nb);
    chk(nd == 6, "R6 down duration on feedback lead", nd, 6);
    chk(nu == 1, "R6 up only overlap cycle", nu, 1);
    chk(nb == 1, "R7 one-cycle overlap lag", nb, 1);

    // R9 mid mode forces commands low
    mode_lvl = 2'b01; do_reset();
    pfd_run(1'b1, 5, nu, nd, nb);
    chk(nu == 0 && nd == 0, "R9 commands off in mid mode", nu + nd, 0);

    // R10 open mode: commands off, monitor shows the edge
    mode_lvl = 2'b10; do_reset();
    cnt = 0;
    @(negedge clk); ref_ce = 1'b1;
    @(negedge clk); ref_ce = 1'b0; if (mon_ref) cnt++;
    repeat (4) begin @(negedge clk); if (pd_up || pd_dn) cnt += 10; end
    chk(cnt == 1, "R10 open mode monitor pulse and cp off", cnt, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

endmodule